// File: doc/BRIEF.md
# Fractional-N Divide Ratio Modulator

This block produces the feedback division for a fractional-N frequency synthesizer loop. It runs on the high-rate clock being divided. A programmable down-counter emits one pulse per output period toward the phase comparator. At the end of each period the counter reloads with a fresh integer ratio. That ratio is the programmed integer part plus a small offset from a third-order noise-shaping interpolator. The interpolator wraps at a programmable modulus, which need not be a power of two. Over many periods the mean ratio equals integer + numerator / modulus.

Configuration is written as one word holding the integer part, the numerator and the modulus. A legal word is held in a shadow copy. It becomes active at the next reload boundary, and the interpolator state is cleared at that boundary. An illegal word is discarded and raises an error flag.

Top module: `fracn_ratio_mod`

## Requirements
- R1: A write (`cfg_we` high at a rising edge) is legal only when 31 ≤ `cfg_int` ≤ 511, 2 ≤ `cfg_mod` ≤ 4095 and `cfg_frac` < `cfg_mod`. An illegal write leaves all configuration untouched and sets `cfg_err` from the next cycle. A legal write clears `cfg_err`.
- R2: `div_pulse` is high for exactly one clock at the end of each output period. A period lasts exactly `div_ratio` clocks, where `div_ratio` is the value loaded at the start of that period.
- R3: Each reloaded ratio equals the active integer part plus an offset in −3..+4, so `div_ratio` needs 10 bits and can exceed 511.
- R4: The offset is c1 + (c2 − c2') + (c3 − 2·c3' + c3''). Here c1, c2 and c3 are the carries of three cascaded accumulators, each reduced modulo the active modulus. The first accumulator adds the numerator, and each later one adds the new value of the one before it. Primes mark the carries of earlier steps. The accumulators step once per reload and never in mid-period.
- R5: While the active numerator is zero, every period lasts exactly the integer part.
- R6: For a fixed configuration, count the K·M consecutive periods that start at the transfer boundary (M = modulus). Their total number of clocks is within 3 of K·(M·int + frac).
- R7: A legal write transfers all three fields together at the next reload. The interpolator is cleared at that point, and the period that starts there lasts exactly the new integer part.
- R8: A write whose sampling edge is also a reload edge does not take effect at that edge. A configuration that was already pending takes effect there instead, and the new write is applied at the following reload.
- R9: After reset the active configuration is integer 31, numerator 0 and modulus 2. `div_ratio` reads 31, `cfg_err` and `div_pulse` are low, and the periods that follow last 31 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | High-rate clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_int | input | 9 | Integer part of the ratio |
| cfg_frac | input | 12 | Fractional numerator |
| cfg_mod | input | 12 | Fractional modulus |
| cfg_err | output | 1 | Last write was rejected |
| div_pulse | output | 1 | One-clock pulse at the end of each divided period |
| div_ratio | output | 10 | Ratio of the period in progress |

## Verification
Two events can fall in one cycle: a configuration write and the counter's terminal count. At that cycle the reload boundary picks between the pending shadow and the word arriving. The bench provokes this by waiting for a negative edge with `div_pulse` high and driving the write there, so the write is sampled on the reload edge itself. It does this once with nothing pending and once with an older legal word already pending. The lengths of the two periods that follow are then measured against the old and the new integer parts. A behavioural model with integer accumulators is also compared with the pulse, the ratio and the error flag on every clock.

// File: rtl/fracn_ratio_mod.sv
module fracn_ratio_mod #(
  parameter int INT_W   = 9,
  parameter int MOD_W   = 12,
  parameter int CNT_W   = 10,
  parameter int INT_MIN = 31,
  parameter int MOD_MIN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [INT_W-1:0] cfg_int,
  input  logic [MOD_W-1:0] cfg_frac,
  input  logic [MOD_W-1:0] cfg_mod,
  output logic             cfg_err,
  output logic             div_pulse,
  output logic [CNT_W-1:0] div_ratio
);

  logic [INT_W-1:0] sh_int, act_int;
  logic [MOD_W-1:0] sh_frac, sh_mod, act_frac, act_mod;
  logic             pend, err_q;
  logic [CNT_W-1:0] cnt, ratio;
  logic [MOD_W-1:0] acc1, acc2, acc3;
  logic             c2_d, c3_d, c3_dd;

  function automatic logic [MOD_W:0] madd(input logic [MOD_W-1:0] a,
                                          input logic [MOD_W-1:0] b,
                                          input logic [MOD_W-1:0] m);
    logic [MOD_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= {1'b0, m}) begin
      s = s - {1'b0, m};
      return {1'b1, s[MOD_W-1:0]};
    end
    return {1'b0, s[MOD_W-1:0]};
  endfunction

  wire wr_ok = cfg_we && (cfg_int >= INT_W'(INT_MIN)) &&
               (cfg_mod >= MOD_W'(MOD_MIN)) && (cfg_frac < cfg_mod);
  wire tc  = (cnt == CNT_W'(1));
  wire run = (act_frac != '0);

  logic [MOD_W:0] s1, s2, s3;
  assign s1 = madd(acc1, act_frac, act_mod);
  assign s2 = madd(acc2, s1[MOD_W-1:0], act_mod);
  assign s3 = madd(acc3, s2[MOD_W-1:0], act_mod);

  wire c1 = s1[MOD_W];
  wire c2 = s2[MOD_W];
  wire c3 = s3[MOD_W];

  logic [CNT_W-1:0] shaped, nxt_ratio;
  assign shaped = CNT_W'(act_int) + CNT_W'(c1) + CNT_W'(c2) + CNT_W'(c3)
                + CNT_W'(c3_dd) - CNT_W'(c2_d) - CNT_W'({c3_d, 1'b0});
  assign nxt_ratio = run ? shaped : CNT_W'(act_int);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_int   <= INT_W'(INT_MIN);
      sh_frac  <= '0;
      sh_mod   <= MOD_W'(MOD_MIN);
      act_int  <= INT_W'(INT_MIN);
      act_frac <= '0;
      act_mod  <= MOD_W'(MOD_MIN);
      pend     <= 1'b0;
      err_q    <= 1'b0;
      cnt      <= CNT_W'(INT_MIN);
      ratio    <= CNT_W'(INT_MIN);
      acc1     <= '0;
      acc2     <= '0;
      acc3     <= '0;
      c2_d     <= 1'b0;
      c3_d     <= 1'b0;
      c3_dd    <= 1'b0;
    end else begin
      if (wr_ok) begin
        sh_int  <= cfg_int;
        sh_frac <= cfg_frac;
        sh_mod  <= cfg_mod;
      end
      pend <= (pend & ~tc) | wr_ok;
      if (cfg_we) err_q <= ~wr_ok;
      if (tc) begin
        if (pend) begin
          act_int  <= sh_int;
          act_frac <= sh_frac;
          act_mod  <= sh_mod;
          acc1     <= '0;
          acc2     <= '0;
          acc3     <= '0;
          c2_d     <= 1'b0;
          c3_d     <= 1'b0;
          c3_dd    <= 1'b0;
          cnt      <= CNT_W'(sh_int);
          ratio    <= CNT_W'(sh_int);
        end else begin
          cnt   <= nxt_ratio;
          ratio <= nxt_ratio;
          if (run) begin
            acc1  <= s1[MOD_W-1:0];
            acc2  <= s2[MOD_W-1:0];
            acc3  <= s3[MOD_W-1:0];
            c2_d  <= c2;
            c3_d  <= c3;
            c3_dd <= c3_d;
          end
        end
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  assign cfg_err   = err_q;
  assign div_pulse = tc;
  assign div_ratio = ratio;

  // R2
  cnt_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt != '0);

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tc |=> cnt == $past(cnt) - CNT_W'(1));

  // R3
  ratio_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(ratio) + 3 >= int'(act_int)) && (int'(ratio) <= int'(act_int) + 4));

  // R4
  acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc1 < act_mod) && (acc2 < act_mod) && (acc3 < act_mod));

  // R4
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tc |=> $stable(acc1) && $stable(acc2) && $stable(acc3));

  // R5
  frac_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_frac == '0) |-> (ratio == CNT_W'(act_int)));

  // R1
  shadow_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sh_int) >= INT_MIN) && (int'(sh_mod) >= MOD_MIN) && (sh_frac < sh_mod));

  // R1
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !wr_ok) |=> cfg_err && $stable(sh_int) && $stable(sh_mod));

  // R7
  transfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && pend) |=> (act_int == $past(sh_int)) && (acc1 == '0) && (acc3 == '0));

  // R8
  defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && !pend && wr_ok) |=> pend && (act_int == $past(act_int)));

endmodule

// File: tb/sim_fracn_ratio_mod.sv
module sim_fracn_ratio_mod;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        we;
  logic [8:0]  in_int;
  logic [11:0] in_frac, in_mod;
  logic        cfg_err, div_pulse;
  logic [9:0]  div_ratio;

  int compared = 0, mismatched = 0;

  always #10 clk = ~clk;

  fracn_ratio_mod u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(we), .cfg_int(in_int),
    .cfg_frac(in_frac), .cfg_mod(in_mod), .cfg_err(cfg_err),
    .div_pulse(div_pulse), .div_ratio(div_ratio)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_cnt, m_ratio, mi, mf, mm, si, sf, sm, a1, a2, a3, k1, k2, k3, d2, d3, dd3;
  bit m_pend, m_err, m_tc, m_ok;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 31; m_ratio = 31; mi = 31; mf = 0; mm = 2; si = 31; sf = 0; sm = 2;
      a1 = 0; a2 = 0; a3 = 0; d2 = 0; d3 = 0; dd3 = 0; m_pend = 0; m_err = 0;
    end else begin
      m_tc = (m_cnt == 1);
      m_ok = we && (int'(in_int) >= 31) && (int'(in_mod) >= 2) && (in_frac < in_mod);
      if (m_tc) begin
        if (m_pend) begin
          mi = si; mf = sf; mm = sm;
          a1 = 0; a2 = 0; a3 = 0; d2 = 0; d3 = 0; dd3 = 0;
          m_ratio = mi;
        end else if (mf != 0) begin
          a1 = a1 + mf; k1 = (a1 >= mm) ? 1 : 0; a1 = a1 % mm;
          a2 = a2 + a1; k2 = (a2 >= mm) ? 1 : 0; a2 = a2 % mm;
          a3 = a3 + a2; k3 = (a3 >= mm) ? 1 : 0; a3 = a3 % mm;
          m_ratio = mi + k1 + (k2 - d2) + (k3 - 2 * d3 + dd3);
          dd3 = d3; d3 = k3; d2 = k2;
        end else begin
          m_ratio = mi;
        end
        m_cnt = m_ratio;
      end else begin
        m_cnt = m_cnt - 1;
      end
      m_pend = (m_pend && !m_tc) || m_ok;
      if (m_ok) begin si = in_int; sf = in_frac; sm = in_mod; end
      if (we) m_err = !m_ok;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(int'(div_pulse) == int'(m_cnt == 1), "R2 pulse", div_pulse, int'(m_cnt == 1));
      check(int'(div_ratio) == m_ratio, "R4 ratio", div_ratio, m_ratio);
      check(int'(cfg_err) == int'(m_err), "R1 err", cfg_err, m_err);
    end
  end

  task automatic wr(input int i, input int f, input int m);
    @(negedge clk);
    while (div_pulse) @(negedge clk);
    we = 1'b1; in_int = 9'(i); in_frac = 12'(f); in_mod = 12'(m);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic wait_cur();
    while (!div_pulse) @(negedge clk);
  endtask

  task automatic wait_next();
    @(negedge clk);
    while (!div_pulse) @(negedge clk);
  endtask

  task automatic measure(input int n, output int tot, output int lo, output int hi);
    tot = 0; lo = 100000; hi = 0;
    for (int j = 0; j < n; j++) begin
      int p;
      p = 0;
      do begin @(negedge clk); p++; end while (!div_pulse);
      tot += p;
      if (p < lo) lo = p;
      if (p > hi) hi = p;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++; compared++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int tot, lo, hi, p, ex;
    rst_n = 1'b0; we = 1'b0; in_int = 9'd31; in_frac = '0; in_mod = 12'd2;
    repeat (4) @(negedge clk);
    check(div_pulse == 1'b0, "R9 pulse in reset", div_pulse, 0);
    check(div_ratio == 10'd31, "R9 ratio in reset", div_ratio, 31);
    check(cfg_err == 1'b0, "R9 err in reset", cfg_err, 0);
    rst_n = 1'b1;
    wait_next();
    measure(2, tot, lo, hi);
    check(lo == 31 && hi == 31, "R9 period after reset", lo, 31);

    // illegal writes
    wr(30, 0, 7);
    check(cfg_err == 1'b1, "R1 int below 31", cfg_err, 1);
    wr(40, 7, 7);
    check(cfg_err == 1'b1, "R1 frac equal to mod", cfg_err, 1);
    wr(40, 0, 1);
    check(cfg_err == 1'b1, "R1 mod below 2", cfg_err, 1);
    wait_cur();
    measure(2, tot, lo, hi);
    check(lo == 31 && hi == 31, "R1 rejected writes leave ratio", hi, 31);

    // integer-only ratio
    wr(40, 0, 7);
    check(cfg_err == 1'b0, "R1 legal write clears err", cfg_err, 0);
    wait_cur();
    measure(5, tot, lo, hi);
    check(lo == 40 && hi == 40, "R5 frac zero divides by int", hi, 40);
    check(tot == 200, "R7 transfer takes new int", tot, 200);

    // fractional averages
    wr(31, 5, 13);
    wait_cur();
    measure(39, tot, lo, hi);
    ex = 3 * (13 * 31 + 5);
    check(tot >= ex - 3 && tot <= ex + 3, "R6 average int31 5/13", tot, ex);
    check(lo >= 28 && hi <= 35, "R3 band at int 31", lo, 28);

    wr(200, 3, 4);
    wait_cur();
    p = 0;
    do begin @(negedge clk); p++; end while (!div_pulse);
    check(p == 200, "R7 first period after transfer", p, 200);
    measure(7, tot, lo, hi);
    tot += p;
    ex = 2 * (4 * 200 + 3);
    check(tot >= ex - 3 && tot <= ex + 3, "R6 average int200 3/4", tot, ex);

    wr(511, 4094, 4095);
    wait_cur();
    measure(40, tot, lo, hi);
    check(hi > 511 && hi <= 515, "R3 ratio above 511", hi, 512);
    check(lo >= 508, "R3 lower band at int 511", lo, 508);

    // write on the reload edge, nothing pending
    wr(60, 0, 5);
    wait_cur();
    measure(2, tot, lo, hi);
    check(tot == 120, "R7 int 60", tot, 120);
    wait_next();
    we = 1'b1; in_int = 9'd80; in_frac = '0; in_mod = 12'd3;
    @(negedge clk);
    we = 1'b0;
    p = 1;
    while (!div_pulse) begin @(negedge clk); p++; end
    check(p == 60, "R8 collided write deferred", p, 60);
    measure(1, tot, lo, hi);
    check(tot == 80, "R8 collided write applied next", tot, 80);

    // write on the reload edge with an older word pending
    wr(70, 0, 9);
    wait_cur();
    we = 1'b1; in_int = 9'd90; in_frac = '0; in_mod = 12'd9;
    @(negedge clk);
    we = 1'b0;
    p = 1;
    while (!div_pulse) begin @(negedge clk); p++; end
    check(p == 70, "R8 pending word wins the edge", p, 70);
    measure(1, tot, lo, hi);
    check(tot == 90, "R8 later word follows", tot, 90);

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule